// File: doc/BRIEF.md
# Shift and Rotate Unit

This unit performs the shift and rotate step of a processor datapath in a single clock. Each accepted operation takes an operand, a shift count and an operation code. It writes the shifted value and five condition flags into registers: carry, extend, overflow, zero and negative. The operand size can be a quarter, a half or the whole of the datapath width `W`. All bit movement, and every flag, is evaluated at the selected size.

Eight operations are provided:

- arithmetic left and logical left shifts;
- arithmetic right and logical right shifts;
- plain left and right rotates;
- left and right rotates that pass through the extend flag.

The through-extend rotates read the extend flag held in the unit's own flag register. Back-to-back operations therefore chain the bit that left one word into the next word, which is how software builds rotates wider than one register. An operation is accepted on a clock edge where `valid_i` is high. Results and flags appear one cycle later and hold while `valid_i` is low.

Top module: `shift_rotate_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the result register and all five flags are cleared to 0.
- R2: An operation presented with `valid_i` high at a clock edge appears on `result_o` and the flag outputs right after that edge. While `valid_i` is low, the result and all flags keep their values.
- R3: The `size_i` field selects the operand size: 2'b00 is W/4 bits, 2'b01 is W/2 bits, and 2'b10 or 2'b11 is W bits. Only the low bits of `operand_i` at that size are used, and result bits above the size read 0. The zero flag is 1 exactly when the sized result is 0. The negative flag is the top bit of the sized result.
- R4: Left shifts insert zeros at bit 0. This covers `op_i` 3'd0 (arithmetic left) and 3'd1 (logical left). For a count c ≥ 1, carry and extend both take the last bit shifted out, which is operand bit N−c for c ≤ N and 0 for c > N. A count c ≥ N gives a zero result.
- R5: After an arithmetic left shift (op 3'd0) with c ≥ 1, overflow is 1 exactly when the sign bit changed value after any of the c single-bit steps. After every other operation, overflow is 0.
- R6: A logical right shift (op 3'd3) fills the vacated top bits with zeros. For c ≥ 1, carry and extend take the last bit shifted out, which is operand bit c−1 for c ≤ N and 0 otherwise.
- R7: An arithmetic right shift (op 3'd2) fills the vacated top bits with copies of the operand's sign bit. For c ≥ 1, carry and extend take operand bit c−1 for c ≤ N, and the sign bit otherwise. A count c ≥ N gives a result of all sign bits.
- R8: A rotate left (op 3'd4) or right (op 3'd5) is circular over N bits. For c ≥ 1, carry takes the last bit that crossed the end: bit 0 of the result for a left rotate, and bit N−1 for a right rotate. The extend flag keeps its value.
- R9: A rotate through extend, left (op 3'd6) or right (op 3'd7), rotates the N+1 bit value formed by the extend flag above the operand. For c ≥ 1, extend takes the bit left in that top position and carry equals the new extend.
- R10: A count of 0 returns the sized operand unchanged, clears carry and overflow, and leaves extend unchanged, for every operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Accept the operation at this edge |
| op_i | input | 3 | Operation code (0 asl, 1 lsl, 2 asr, 3 lsr, 4 rol, 5 ror, 6 rol through extend, 7 ror through extend) |
| size_i | input | 2 | Operand size select |
| count_i | input | CW | Shift or rotate count |
| operand_i | input | W | Source operand |
| result_o | output | W | Registered result, zero above the selected size |
| carry_o | output | 1 | Carry flag |
| extend_o | output | 1 | Extend flag |
| overflow_o | output | 1 | Overflow flag |
| zero_o | output | 1 | Zero flag |
| negative_o | output | 1 | Negative flag |

## Verification
The extend flag is the only state carried from one operation to the next. A wrong extend value therefore stays hidden until the next rotate through extend. That rotate then places the stale bit at bit 0 or at the top of the result, visible one cycle after it is accepted. The bench sweeps every operation at every size through counts from 0 to past N+1, and it follows extend with its own model across the whole sequence. A corrupted extend is therefore caught at the first chained rotate that follows. A wrong size choice, or a bad overflow or carry term, shows on the very next result, or on the flag outputs of that same cycle.

// File: rtl/sru_pkg.sv
package sru_pkg;

    typedef enum logic [2:0] {
        OP_ASL  = 3'd0,
        OP_LSL  = 3'd1,
        OP_ASR  = 3'd2,
        OP_LSR  = 3'd3,
        OP_ROL  = 3'd4,
        OP_ROR  = 3'd5,
        OP_ROXL = 3'd6,
        OP_ROXR = 3'd7
    } sru_op_e;

    typedef enum logic [1:0] {
        SZ_QUARTER = 2'b00,
        SZ_HALF    = 2'b01,
        SZ_FULL    = 2'b10,
        SZ_FULL_R  = 2'b11
    } sru_size_e;

    typedef struct packed {
        logic ext;
        logic neg;
        logic zer;
        logic ovf;
        logic cry;
    } sru_flags_t;

    localparam int NUM_LANES = 3;

    function automatic logic is_shift(input sru_op_e op);
        return (op == OP_ASL) || (op == OP_LSL) || (op == OP_ASR) || (op == OP_LSR);
    endfunction

    function automatic int size_to_lane(input sru_size_e sz);
        case (sz)
            SZ_QUARTER: return 0;
            SZ_HALF:    return 1;
            default:    return 2;
        endcase
    endfunction

endpackage

// File: rtl/sru_lane.sv
module sru_lane
    import sru_pkg::*;
#(
    parameter int N  = 8,
    parameter int CW = 6
) (
    input  logic [N-1:0]  operand,
    input  logic          x_in,
    input  logic [CW-1:0] count,
    input  sru_op_e       op,
    output logic [N-1:0]  res,
    output logic          c_out,
    output logic          x_out,
    output logic          v_out
);

    logic          nz;
    logic [CW-1:0] rot_n;
    logic [CW-1:0] rot_x;
    logic [N:0]    lft;
    logic [N:0]    rlog;
    logic [N:0]    rari;
    logic [N-1:0]  rol_v;
    logic [N-1:0]  ror_v;
    logic [N:0]    ext_v;
    logic [N:0]    roxl_v;
    logic [N:0]    roxr_v;
    logic [N-1:0]  diff;
    logic [N-1:0]  topm;
    logic [CW:0]   cnt_p1;
    logic          big;
    logic          ovf_calc;

    assign nz     = |count;
    assign rot_n  = CW'(count % N);
    assign rot_x  = CW'(count % (N + 1));
    assign cnt_p1 = {1'b0, count} + (CW+1)'(1);
    assign big    = int'(count) >= N;

    // left shift: bit N collects the most recent bit pushed out
    assign lft  = {1'b0, operand} << count;
    // right shifts: bit 0 collects the most recent bit pushed out
    assign rlog = {operand, 1'b0} >> count;
    assign rari = $signed({operand, 1'b0}) >>> count;

    assign rol_v = (operand << rot_n) | (operand >> (N - int'(rot_n)));
    assign ror_v = (operand >> rot_n) | (operand << (N - int'(rot_n)));

    assign ext_v  = {x_in, operand};
    assign roxl_v = (ext_v << rot_x) | (ext_v >> (N + 1 - int'(rot_x)));
    assign roxr_v = (ext_v >> rot_x) | (ext_v << (N + 1 - int'(rot_x)));

    // sign moves through the c bits just below it during an arithmetic left shift
    assign diff     = operand ^ {N{operand[N-1]}};
    assign topm     = ~({N{1'b1}} >> cnt_p1);
    assign ovf_calc = big ? (|operand) : (|(diff & topm));

    always_comb begin
        res   = operand;
        c_out = 1'b0;
        x_out = x_in;
        v_out = 1'b0;
        case (op)
            OP_ASL, OP_LSL: begin
                res   = lft[N-1:0];
                c_out = lft[N];
                v_out = (op == OP_ASL) && nz && ovf_calc;
            end
            OP_ASR: begin
                res   = rari[N:1];
                c_out = rari[0];
            end
            OP_LSR: begin
                res   = rlog[N:1];
                c_out = rlog[0];
            end
            OP_ROL: begin
                res   = rol_v;
                c_out = nz & rol_v[0];
            end
            OP_ROR: begin
                res   = ror_v;
                c_out = nz & ror_v[N-1];
            end
            OP_ROXL: begin
                res   = roxl_v[N-1:0];
                c_out = nz & roxl_v[N];
                x_out = nz ? roxl_v[N] : x_in;
            end
            default: begin
                res   = roxr_v[N-1:0];
                c_out = nz & roxr_v[N];
                x_out = nz ? roxr_v[N] : x_in;
            end
        endcase
        if (is_shift(op) && nz) begin
            x_out = c_out;
        end
    end

endmodule

// File: rtl/sru_state.sv
module sru_state
    import sru_pkg::*;
#(
    parameter int W = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [W-1:0] d_res,
    input  sru_flags_t d_flags,
    output logic [W-1:0] q_res,
    output sru_flags_t q_flags
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_res   <= '0;
            q_flags <= '0;
        end else if (load) begin
            q_res   <= d_res;
            q_flags <= d_flags;
        end
    end

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
    import sru_pkg::*;
#(
    parameter int W  = 32,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid_i,
    input  logic [2:0]    op_i,
    input  logic [1:0]    size_i,
    input  logic [CW-1:0] count_i,
    input  logic [W-1:0]  operand_i,
    output logic [W-1:0]  result_o,
    output logic          carry_o,
    output logic          extend_o,
    output logic          overflow_o,
    output logic          zero_o,
    output logic          negative_o
);

    sru_op_e    op;
    sru_flags_t flags_q;
    sru_flags_t flags_d;
    logic [W-1:0] sel_res;

    logic [W-1:0] lane_res [NUM_LANES];
    logic         lane_c   [NUM_LANES];
    logic         lane_x   [NUM_LANES];
    logic         lane_v   [NUM_LANES];
    logic         lane_n   [NUM_LANES];

    assign op = sru_op_e'(op_i);

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        localparam int LW = W >> (NUM_LANES - 1 - i);
        logic [LW-1:0] r;
        sru_lane #(.N(LW), .CW(CW)) u_lane (
            .operand (operand_i[LW-1:0]),
            .x_in    (flags_q.ext),
            .count   (count_i),
            .op      (op),
            .res     (r),
            .c_out   (lane_c[i]),
            .x_out   (lane_x[i]),
            .v_out   (lane_v[i])
        );
        assign lane_res[i] = W'(r);
        assign lane_n[i]   = r[LW-1];
    end

    always_comb begin
        int k;
        k           = size_to_lane(sru_size_e'(size_i));
        sel_res     = lane_res[k];
        flags_d.cry = lane_c[k];
        flags_d.ext = lane_x[k];
        flags_d.ovf = lane_v[k];
        flags_d.neg = lane_n[k];
        flags_d.zer = ~|lane_res[k];
    end

    sru_state #(.W(W)) u_state (
        .clk     (clk),
        .rst     (rst),
        .load    (valid_i),
        .d_res   (sel_res),
        .d_flags (flags_d),
        .q_res   (result_o),
        .q_flags (flags_q)
    );

    assign carry_o    = flags_q.cry;
    assign extend_o   = flags_q.ext;
    assign overflow_o = flags_q.ovf;
    assign zero_o     = flags_q.zer;
    assign negative_o = flags_q.neg;

endmodule

// File: rtl/sru_checker.sv
module sru_checker
    import sru_pkg::*;
#(
    parameter int W  = 32,
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          valid_i,
    input logic [2:0]    op_i,
    input logic [1:0]    size_i,
    input logic [CW-1:0] count_i,
    input logic [W-1:0]  result_o,
    input logic          carry_o,
    input logic          extend_o,
    input logic          overflow_o,
    input logic          zero_o,
    input logic          negative_o
);

    localparam int QW = W / 4;

    // R2: nothing moves while no operation is accepted
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(result_o) && $stable(carry_o) && $stable(extend_o)
                     && $stable(overflow_o) && $stable(zero_o) && $stable(negative_o));

    // R3: quarter size clears upper bits and takes sign from the quarter msb
    p_quarter_r3: assert property (@(posedge clk) disable iff (rst)
        valid_i && size_i == 2'b00 |=> result_o[W-1:QW] == '0 && negative_o == result_o[QW-1]);

    // R3: zero flag tracks the stored result
    p_zero_flag_r3: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> zero_o == (result_o == '0));

    // R5: only arithmetic left shift raises overflow
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        valid_i && op_i != 3'd0 |=> !overflow_o);

    // R4: shifts with a nonzero count copy carry into extend
    p_shift_ext_r4: assert property (@(posedge clk) disable iff (rst)
        valid_i && op_i < 3'd4 && count_i != '0 |=> extend_o == carry_o);

    // R8: plain rotates leave extend alone
    p_rot_keeps_x_r8: assert property (@(posedge clk) disable iff (rst)
        valid_i && (op_i == 3'd4 || op_i == 3'd5) |=> $stable(extend_o));

    // R9: through-extend rotates with a nonzero count set carry equal to extend
    p_rox_cx_r9: assert property (@(posedge clk) disable iff (rst)
        valid_i && op_i >= 3'd6 && count_i != '0 |=> carry_o == extend_o);

    // R10: zero count clears carry and keeps extend
    p_zero_count_r10: assert property (@(posedge clk) disable iff (rst)
        valid_i && count_i == '0 |=> !carry_o && $stable(extend_o));

endmodule

bind shift_rotate_unit sru_checker #(.W(W), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .valid_i    (valid_i),
    .op_i       (op_i),
    .size_i     (size_i),
    .count_i    (count_i),
    .result_o   (result_o),
    .carry_o    (carry_o),
    .extend_o   (extend_o),
    .overflow_o (overflow_o),
    .zero_o     (zero_o),
    .negative_o (negative_o)
);

// File: tb/shift_rotate_unit_tb.sv
module shift_rotate_unit_tb;

    localparam int W  = 16;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          valid_i = 1'b0;
    logic [2:0]    op_i = '0;
    logic [1:0]    size_i = '0;
    logic [CW-1:0] count_i = '0;
    logic [W-1:0]  operand_i = '0;
    logic [W-1:0]  result_o;
    logic          carry_o, extend_o, overflow_o, zero_o, negative_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic model_x = 1'b0;

    shift_rotate_unit #(.W(W), .CW(CW)) u_dut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .size_i(size_i),
        .count_i(count_i), .operand_i(operand_i), .result_o(result_o),
        .carry_o(carry_o), .extend_o(extend_o), .overflow_o(overflow_o),
        .zero_o(zero_o), .negative_o(negative_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic [15:0] mask_of(input int n);
        return (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
    endfunction

    task automatic check(input string tag, input logic [21:0] act, input logic [21:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // step-by-step reference: one bit moved per iteration
    task automatic model(input int op, input int n, input int cnt, input logic [15:0] a,
                         input logic xin, output logic [15:0] r, output logic c,
                         output logic x, output logic v);
        logic [15:0] val;
        logic [15:0] m;
        logic        out;
        m   = mask_of(n);
        val = a & m;
        c = 1'b0; x = xin; v = 1'b0; out = 1'b0;
        for (int k = 0; k < cnt; k++) begin
            case (op)
                0, 1: begin
                    out = val[n-1];
                    val = (val << 1) & m;
                    if (op == 0 && val[n-1] != out) v = 1'b1;
                end
                2: begin
                    out = val[0];
                    val = (val >> 1) | (16'(val[n-1]) << (n-1));
                end
                3: begin
                    out = val[0];
                    val = val >> 1;
                end
                4: begin
                    out = val[n-1];
                    val = ((val << 1) & m) | 16'(out);
                end
                5: begin
                    out = val[0];
                    val = (val >> 1) | (16'(out) << (n-1));
                end
                6: begin
                    out = val[n-1];
                    val = ((val << 1) & m) | 16'(x);
                    x = out;
                end
                default: begin
                    out = val[0];
                    val = (val >> 1) | (16'(x) << (n-1));
                    x = out;
                end
            endcase
            c = out;
            if (op < 4) x = out;
        end
        r = val;
    endtask

    task automatic run_op(input int op, input int sz, input int cnt, input logic [15:0] a);
        int n;
        string tag;
        logic [15:0] er;
        logic ec, ex, ev;
        n = (sz == 0) ? 4 : (sz == 1) ? 8 : 16;
        @(negedge clk);
        valid_i = 1'b1; op_i = 3'(op); size_i = 2'(sz); count_i = CW'(cnt); operand_i = a;
        @(posedge clk);
        #5;
        valid_i = 1'b0;
        model(op, n, cnt, a, model_x, er, ec, ex, ev);
        model_x = ex;
        if (cnt == 0)               tag = "R10";
        else if (op == 0)           tag = "R5";
        else if (op == 1)           tag = "R4";
        else if (op == 2)           tag = "R7";
        else if (op == 3)           tag = "R6";
        else if (op < 6)            tag = "R8";
        else                        tag = "R9";
        check(tag, {1'b0, result_o, carry_o, extend_o, overflow_o, zero_o, negative_o},
              {1'b0, er, ec, ex, ev, er == 16'h0, er[n-1]});
        // R3: bits above the selected size stay clear
        check("R3", 22'(result_o & ~mask_of(n)), 22'h0);
    endtask

    task automatic hold_check(input int op);
        logic [15:0] r0;
        logic [4:0]  f0;
        r0 = result_o;
        f0 = {carry_o, extend_o, overflow_o, zero_o, negative_o};
        @(negedge clk);
        valid_i = 1'b0; op_i = 3'(op); size_i = 2'b10; count_i = CW'(3); operand_i = 16'hA5C3;
        @(posedge clk);
        #5;
        // R2: inputs without valid change nothing
        check("R2", {1'b0, result_o, carry_o, extend_o, overflow_o, zero_o, negative_o},
              {1'b0, r0, f0});
    endtask

    logic [15:0] pats [6];

    initial begin
        pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'h8001;
        pats[3] = 16'h5A3C; pats[4] = 16'h7FFE; pats[5] = 16'hC3A5;
        repeat (3) @(posedge clk);
        #5;
        // R1: reset state
        check("R1", {1'b0, result_o, carry_o, extend_o, overflow_o, zero_o, negative_o}, 22'h0);
        @(negedge clk);
        rst = 1'b0;
        model_x = 1'b0;
        for (int sz = 0; sz < 4; sz++) begin
            for (int op = 0; op < 8; op++) begin
                int n;
                n = (sz == 0) ? 4 : (sz == 1) ? 8 : 16;
                for (int p = 0; p < 6; p++) begin
                    for (int cnt = 0; cnt <= n + 2; cnt++) begin
                        run_op(op, sz, cnt, pats[p]);
                    end
                    run_op(op, sz, (1 << CW) - 1, pats[p]);
                end
                hold_check(op);
            end
        end
        // chained multi-precision rotate through extend: set extend to 1 first
        run_op(1, 2, 1, 16'h8000);
        run_op(6, 2, 1, 16'h0000);
        run_op(7, 0, 1, 16'h0001);
        run_op(7, 0, 1, 16'h0000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule